// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a bank of single-bit lock flags that two independent agents, a left port and a right port, use to agree on ownership of shared resources. Each port drives its own memory chip-enable, semaphore select, write strobe, flag address and data bus. It returns its own registered read bus. A port claims a flag by writing a zero in data bit 0 and gives the flag up by writing a one. It learns whether it holds the flag by reading the flag back.

The unit runs on one clock. All strobes are active-high and sampled on the rising edge. The asynchronous active-low reset releases every flag. Each flag keeps an ownership bit and a pending-request bit for each side. A request made while the opposite side holds the flag is recorded as pending. That pending request becomes ownership on the same edge at which the holder lets go. When both sides ask for a free flag in the same cycle, a parity register that toggles every cycle since reset picks the winner. The left port wins on even cycles and the right port on odd cycles. The losing side is left pending.

Top module: `dual_sem_unit`

## Requirements
- R1: After reset every flag is released, both read buses show 8'hFF, and any flag read from either port returns 8'hFF.
- R2: A port reaches the semaphores only when its chip-enable is 0 and its semaphore select is 1. A write strobe with chip-enable at 1, or with semaphore select at 0, changes no flag.
- R3: The address input picks one of the eight flags. A semaphore write with data bit 0 at 0 is a request, and a write with data bit 0 at 1 is a release. Data bits 7 to 1 have no effect.
- R4: A semaphore read (write strobe 0) loads the port's read bus on the next edge. The value is 8'h00 if that port owns the addressed flag and 8'hFF otherwise. A read issued in the cycle right after a write shows the result of that write.
- R5: A request for a flag that the opposite port owns does not grant it. It is held as pending.
- R6: When the owner releases a flag on which the other port has a pending request, the other port owns it from that same edge.
- R7: A release clears the releasing port's ownership or its pending request on that flag. The flag is then not later granted to that port.
- R8: At most one port owns a flag at any time. When both ports request the same free flag in one cycle, the left port wins if the number of clock edges since reset is even, the right port wins if it is odd, and the loser becomes pending.
- R9: Operations on one flag leave the state of every other flag unchanged.
- R10: The read bus of a port holds its last value in cycles with no semaphore read on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_i | input | 1 | Left memory chip-enable, active high |
| l_sem_i | input | 1 | Left semaphore select, active high |
| l_we_i | input | 1 | Left write strobe (0 = read) |
| l_addr_i | input | 3 | Left flag address |
| l_wdata_i | input | 8 | Left write data, bit 0 is used |
| l_rdata_o | output | 8 | Left registered read data |
| r_ce_i | input | 1 | Right memory chip-enable, active high |
| r_sem_i | input | 1 | Right semaphore select, active high |
| r_we_i | input | 1 | Right write strobe (0 = read) |
| r_addr_i | input | 3 | Right flag address |
| r_wdata_i | input | 8 | Right write data, bit 0 is used |
| r_rdata_o | output | 8 | Right registered read data |

## Verification
The bench aims first at same-cycle contention and runs it at both parities. A design that reversed the parity rule, or granted both sides, would show the wrong or a duplicate owner on readback. It then checks the hand-off of a pending request at the moment of release, and the cancellation of a pending request by its own release. A design that dropped the pending bit would leave the flag free, and one that kept a cancelled pending bit would hand out a lock nobody asked for. Memory-mode writes, deselected writes and writes with junk in the upper data bits are checked to prove the decode. A read in the cycle right after a write catches a design that adds an extra stage of latency.

// File: rtl/sem_pkg.sv
package sem_pkg;
  // parity winner encoding: even edge -> left
  typedef enum logic {
    WIN_LEFT  = 1'b0,
    WIN_RIGHT = 1'b1
  } win_e;

  localparam int unsigned SEM_FLAGS_DEF = 8;
  localparam int unsigned SEM_DATA_DEF  = 8;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NUM_FLAGS = 8,
  localparam int ADDR_W = $clog2(NUM_FLAGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_i,
  input  logic                 sem_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 bit0_i,
  output logic [NUM_FLAGS-1:0] req_o,
  output logic [NUM_FLAGS-1:0] rel_o,
  output logic                 rd_o
);
  logic sel;
  logic [NUM_FLAGS-1:0] hit;

  assign sel = sem_i & ~ce_i;

  always_comb begin
    hit = '0;
    hit[addr_i] = 1'b1;
  end

  assign req_o = (sel & we_i & ~bit0_i) ? hit : '0;
  assign rel_o = (sel & we_i &  bit0_i) ? hit : '0;
  assign rd_o  = sel & ~we_i;

  // R2
  mem_mode_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i || !sem_i) |-> (req_o == '0 && rel_o == '0 && !rd_o));
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  win_e prio_i,
  input  logic req_l_i,
  input  logic rel_l_i,
  input  logic req_r_i,
  input  logic rel_r_i,
  output logic own_l_o,
  output logic own_r_o
);
  logic own_l_q, own_r_q, pend_l_q, pend_r_q;
  logic own_l_d, own_r_d, pend_l_d, pend_r_d;
  logic keep_l, keep_r, want_l, want_r;

  assign keep_l = own_l_q & ~rel_l_i;
  assign keep_r = own_r_q & ~rel_r_i;
  assign want_l = ~rel_l_i & ~own_l_q & (req_l_i | pend_l_q);
  assign want_r = ~rel_r_i & ~own_r_q & (req_r_i | pend_r_q);

  always_comb begin
    own_l_d  = 1'b0;
    own_r_d  = 1'b0;
    pend_l_d = 1'b0;
    pend_r_d = 1'b0;
    if (keep_l) begin
      own_l_d  = 1'b1;
      pend_r_d = want_r;
    end else if (keep_r) begin
      own_r_d  = 1'b1;
      pend_l_d = want_l;
    end else if (want_l && want_r) begin
      // same-cycle tie on a free flag
      if (prio_i == WIN_LEFT) begin
        own_l_d  = 1'b1;
        pend_r_d = 1'b1;
      end else begin
        own_r_d  = 1'b1;
        pend_l_d = 1'b1;
      end
    end else begin
      own_l_d = want_l;
      own_r_d = want_r;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_l_q  <= 1'b0;
      own_r_q  <= 1'b0;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      own_l_q  <= own_l_d;
      own_r_q  <= own_r_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign own_l_o = own_l_q;
  assign own_r_o = own_r_q;

  // R8
  single_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(own_l_q && own_r_q));
  // R5
  pend_l_holder_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_l_q |-> own_r_q);
  // R5
  pend_r_holder_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_r_q |-> own_l_q);
  // R6
  handoff_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_l_q && rel_r_i && !rel_l_i) |=> own_l_q);
  // R6
  handoff_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_r_q && rel_l_i && !rel_r_i) |=> own_r_q);
endmodule

// File: rtl/sem_rd_port.sv
module sem_rd_port #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W = $clog2(NUM_FLAGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_FLAGS-1:0] own_i,
  output logic [DATA_W-1:0]    rdata_o
);
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '1;
    else if (rd_i) rdata_q <= {DATA_W{~own_i[addr_i]}};
  end

  assign rdata_o = rdata_q;

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/dual_sem_unit.sv
module dual_sem_unit
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = SEM_FLAGS_DEF,
  parameter int DATA_W    = SEM_DATA_DEF,
  localparam int ADDR_W = $clog2(NUM_FLAGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_i,
  input  logic              l_sem_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_ce_i,
  input  logic              r_sem_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  logic [NUM_FLAGS-1:0] req_l, rel_l, req_r, rel_r, own_l, own_r;
  logic rd_l, rd_r;
  win_e par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) par_q <= WIN_LEFT;
    else         par_q <= (par_q == WIN_LEFT) ? WIN_RIGHT : WIN_LEFT;
  end

  sem_port_dec #(.NUM_FLAGS(NUM_FLAGS)) u_dec_l (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(l_ce_i), .sem_i(l_sem_i),
    .we_i(l_we_i), .addr_i(l_addr_i), .bit0_i(l_wdata_i[0]),
    .req_o(req_l), .rel_o(rel_l), .rd_o(rd_l)
  );

  sem_port_dec #(.NUM_FLAGS(NUM_FLAGS)) u_dec_r (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(r_ce_i), .sem_i(r_sem_i),
    .we_i(r_we_i), .addr_i(r_addr_i), .bit0_i(r_wdata_i[0]),
    .req_o(req_r), .rel_o(rel_r), .rd_o(rd_r)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sem_flag_cell u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .prio_i(par_q),
      .req_l_i(req_l[g]), .rel_l_i(rel_l[g]),
      .req_r_i(req_r[g]), .rel_r_i(rel_r[g]),
      .own_l_o(own_l[g]), .own_r_o(own_r[g])
    );
  end

  sem_rd_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_l (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_l), .addr_i(l_addr_i),
    .own_i(own_l), .rdata_o(l_rdata_o)
  );

  sem_rd_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_r (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_r), .addr_i(r_addr_i),
    .own_i(own_r), .rdata_o(r_rdata_o)
  );

  // R8
  parity_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> par_q != $past(par_q));
  // R9
  flag_isolation_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_l | rel_l | req_r | rel_r) == '0) |=> $stable(own_l) && $stable(own_r));
endmodule

// File: tb/sim_dual_sem_unit.sv
`timescale 1ns/1ps
module sim_dual_sem_unit;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic l_ce, l_sem, l_we, r_ce, r_sem, r_we;
  logic [2:0] l_addr, r_addr;
  logic [7:0] l_wd, r_wd, l_rd, r_rd;
  int checks = 0;
  int fails = 0;
  int edge_cnt = 0;

  typedef struct {
    int         due;
    bit         side;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  dual_sem_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_ce_i(l_ce), .l_sem_i(l_sem), .l_we_i(l_we), .l_addr_i(l_addr),
    .l_wdata_i(l_wd), .l_rdata_o(l_rd),
    .r_ce_i(r_ce), .r_sem_i(r_sem), .r_we_i(r_we), .r_addr_i(r_addr),
    .r_wdata_i(r_wd), .r_rdata_o(r_rd)
  );

  always @(posedge clk) if (rst_ni) edge_cnt <= edge_cnt + 1;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare read results one edge after issue
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= edge_cnt) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, it.side ? r_rd : l_rd, it.exp);
    end
  end

  // kinds: 0 idle, 1 sem write, 2 sem read, 3 write with ce high, 4 write deselected
  task automatic drv(input bit side, input int k, input int a, input logic [7:0] d,
                     input logic [7:0] exp, input string tag);
    logic ce, sem, we;
    ce = 1'b0; sem = 1'b0; we = 1'b0;
    case (k)
      1: begin sem = 1'b1; we = 1'b1; end
      2: begin sem = 1'b1; end
      3: begin ce = 1'b1; sem = 1'b1; we = 1'b1; end
      4: begin we = 1'b1; end
      default: ;
    endcase
    if (side) begin
      r_ce = ce; r_sem = sem; r_we = we; r_addr = 3'(a); r_wd = d;
    end else begin
      l_ce = ce; l_sem = sem; l_we = we; l_addr = 3'(a); l_wd = d;
    end
    if (k == 2) begin
      item_t it;
      it.due = edge_cnt + 1; it.side = side; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
    end
  endtask

  task automatic step(input int lk, input int la, input logic [7:0] ld, input logic [7:0] lx,
                      input int rk, input int ra, input logic [7:0] rd, input logic [7:0] rx,
                      input string tag);
    drv(1'b0, lk, la, ld, lx, {tag, " left"});
    drv(1'b1, rk, ra, rd, rx, {tag, " right"});
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 8'h00, 8'h00, 0, 0, 8'h00, 8'h00, "idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    l_ce = 0; l_sem = 0; l_we = 0; l_addr = 0; l_wd = 0;
    r_ce = 0; r_sem = 0; r_we = 0; r_addr = 0; r_wd = 0;
    repeat (3) @(negedge clk);
    check("R1 reset left bus", l_rd, 8'hFF);
    check("R1 reset right bus", r_rd, 8'hFF);
    rst_ni = 1'b1;

    // R1 all released
    for (int f = 0; f < 8; f++) step(2, f, 0, 8'hFF, 2, 7 - f, 0, 8'hFF, "R1 released");

    // R3 R4 request then immediate read
    step(1, 3, 8'h00, 0, 0, 0, 0, 0, "R3 req");
    step(2, 3, 0, 8'h00, 2, 3, 0, 8'hFF, "R4 read after write");
    // R5 right asks for held flag
    step(0, 0, 0, 0, 1, 3, 8'h00, 0, "R5 req");
    step(2, 3, 0, 8'h00, 2, 3, 0, 8'hFF, "R5 pending not granted");
    // R6 left release hands to right
    step(1, 3, 8'h01, 0, 0, 0, 0, 0, "R6 rel");
    step(2, 3, 0, 8'hFF, 2, 3, 0, 8'h00, "R6 handoff");
    // R7 release of owned
    step(0, 0, 0, 0, 1, 3, 8'h01, 0, "R7 rel");
    step(2, 3, 0, 8'hFF, 2, 3, 0, 8'hFF, "R7 released");

    // R7 cancel a pending request
    step(1, 5, 8'h00, 0, 0, 0, 0, 0, "R7 setup");
    step(0, 0, 0, 0, 1, 5, 8'h00, 0, "R7 pend");
    step(0, 0, 0, 0, 1, 5, 8'h01, 0, "R7 cancel");
    step(1, 5, 8'h01, 0, 0, 0, 0, 0, "R7 owner rel");
    step(2, 5, 0, 8'hFF, 2, 5, 0, 8'hFF, "R7 pending cancelled");

    // R2 decode
    step(3, 1, 8'h00, 0, 3, 1, 8'h00, 0, "R2 ce");
    step(4, 1, 8'h00, 0, 4, 1, 8'h00, 0, "R2 desel");
    step(2, 1, 0, 8'hFF, 2, 1, 0, 8'hFF, "R2 ignored");

    // R3 upper data bits ignored
    step(1, 2, 8'hAA, 0, 0, 0, 0, 0, "R3 req AA");
    step(2, 2, 0, 8'h00, 2, 2, 0, 8'hFF, "R3 AA is request");
    step(1, 2, 8'h55, 0, 0, 0, 0, 0, "R3 rel 55");
    step(2, 2, 0, 8'hFF, 0, 0, 0, 0, "R3 55 is release");

    // R8 contention at both parities
    for (int p = 0; p < 2; p++) begin
      logic [7:0] lx, rx;
      while ((edge_cnt % 2) != p) idle();
      lx = (p == 0) ? 8'h00 : 8'hFF;
      rx = (p == 0) ? 8'hFF : 8'h00;
      step(1, 6, 8'h00, 0, 1, 6, 8'h00, 0, "R8 tie");
      step(2, 6, 0, lx, 2, 6, 0, rx, "R8 winner");
      if (p == 0) step(1, 6, 8'h01, 0, 0, 0, 0, 0, "R8 rel winner");
      else        step(0, 0, 0, 0, 1, 6, 8'h01, 0, "R8 rel winner");
      step(2, 6, 0, rx, 2, 6, 0, lx, "R8 loser pending granted");
      if (p == 0) step(0, 0, 0, 0, 1, 6, 8'h01, 0, "R8 clean");
      else        step(1, 6, 8'h01, 0, 0, 0, 0, 0, "R8 clean");
    end

    // R9 independence
    step(1, 0, 8'h00, 0, 1, 7, 8'h00, 0, "R9 two flags");
    step(2, 0, 0, 8'h00, 2, 7, 0, 8'h00, "R9 both own");
    step(2, 7, 0, 8'hFF, 2, 0, 0, 8'hFF, "R9 cross view");
    step(2, 4, 0, 8'hFF, 2, 4, 0, 8'hFF, "R9 untouched");

    // R10 hold
    step(2, 0, 0, 8'h00, 2, 0, 0, 8'hFF, "R10 prime");
    idle(); idle();
    check("R10 left hold", l_rd, 8'h00);
    check("R10 right hold", r_rd, 8'hFF);

    idle(); idle();
    check("scoreboard drained", 8'(sb_q.size()), 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule